// File: doc/BRIEF.md
# DRAM Refresh Request Queue

This block paces DRAM refresh. A free-running cycle timer produces one refresh tick every programmable number of clock cycles; for example, 1560 cycles at 100 MHz gives the usual 15.6 µs refresh period. Each tick adds one entry to a counting queue of owed refreshes. The memory arbiter reports every refresh it actually performs with a one-cycle acknowledge, and each acknowledge removes one entry from the queue.

The arbiter sees the owed work through two request levels. A small backlog raises only the low-priority request, so the arbiter can hold refresh back behind other masters. Once the backlog reaches the high-water mark, the block switches to the high-priority request, which asks the arbiter to stop deferring. The queue holds at most twelve owed refreshes. A tick that arrives with the queue full is lost, and a sticky flag records the loss until the next reset.

Top module: `refq_top`

## Requirements
- R1: After reset is released, the first tick takes effect on the N-th rising clock edge, where N is the programmed interval. The pending count becomes 1 after that edge and not before.
- R2: Without an acknowledge, every tick raises the pending count by exactly one while the count is below 12. Ticks then repeat every N cycles.
- R3: An acknowledge in a cycle without a tick lowers a nonzero pending count by exactly one on the next edge.
- R4: A tick and an acknowledge in the same cycle, with a nonzero pending count, leave the count unchanged.
- R5: An acknowledge while the pending count is 0 has no effect. The count stays 0 if there is no tick, and becomes 1 if there is one.
- R6: While the pending count is 1 to 7, the low-priority request is 1 and the high-priority request is 0. While the count is 0, both requests are 0.
- R7: While the pending count is 8 to 12, the high-priority request is 1 and the low-priority request is 0.
- R8: A tick without an acknowledge while the count is 12 is dropped. The count stays 12, and the overflow flag goes to 1 and stays 1 until reset, whatever the later acknowledges do.
- R9: Reset (active low) clears the pending count, the overflow flag and the cycle timer. Both requests are 0 during reset.
- R10: An interval value of 0 or 1 makes a tick occur on every clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intervalCnt | input | 16 | Refresh interval in clock cycles |
| refAck | input | 1 | One-cycle pulse per refresh performed by the arbiter |
| reqLow | output | 1 | Low-priority refresh request |
| reqHigh | output | 1 | High-priority refresh request |
| pendCount | output | 4 | Number of owed refreshes (0 to 12) |
| overflow | output | 1 | Sticky flag: a tick was lost with the queue full |

## Verification
The bench drives four acknowledge patterns.

- **No acknowledges at all:** the count climbs through both priority bands into the full state. This shows the tick spacing, the band switch at 8, and the drop with overflow at 12.
- **An acknowledge on every cycle:** the count drains to zero while ticks keep arriving. This separates a plain decrement, an acknowledge ignored at zero, and a tick that collides with an acknowledge. Overflow must stay set throughout.
- **Random acknowledges at two densities:** these hit same-cycle collisions at many fill levels, so a design that lets the acknowledge or the tick win a collision is told apart from a correct one.
- **Intervals of 1 and 0, and a reset mid-run:** the short intervals confirm the tick-every-edge case. The reset checks that the timer phase is cleared as well as the count.

// File: rtl/refq_pkg.sv
package refq_pkg;
  // strobes from control to datapath, at most one of them set per cycle
  typedef struct packed {
    logic inc;   // add one owed refresh
    logic dec;   // retire one owed refresh
    logic drop;  // tick lost on a full queue
  } refqStrobe_t;
endpackage

// File: rtl/refq_timer.sv
module refq_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] intervalCnt,
  output logic             tick
);
  logic [TMR_W-1:0] tmrCnt;
  logic [TMR_W-1:0] tmrLimit;

  // intervals of 0 and 1 both mean a tick on every edge
  always_comb begin
    if (intervalCnt <= TMR_W'(1)) tmrLimit = '0;
    else                          tmrLimit = intervalCnt - TMR_W'(1);
    // >= keeps the timer sane if the interval shrinks mid-count
    tick = (tmrCnt >= tmrLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN)     tmrCnt <= '0;
    else if (tick) tmrCnt <= '0;
    else           tmrCnt <= tmrCnt + TMR_W'(1);
  end
endmodule

// File: rtl/refq_ctrl.sv
module refq_ctrl
  import refq_pkg::*;
#(
  parameter int MAX_PEND = 12,
  localparam int PEND_W  = $clog2(MAX_PEND + 1)
) (
  input  logic              tick,
  input  logic              refAck,
  input  logic [PEND_W-1:0] pendCount,
  output refqStrobe_t       strobe
);
  logic ackValid;
  logic atFull;

  always_comb begin
    // an acknowledge with nothing owed is meaningless and ignored
    ackValid    = refAck && (pendCount != '0);
    atFull      = (pendCount == PEND_W'(MAX_PEND));
    strobe.inc  = tick && !ackValid && !atFull;
    strobe.drop = tick && !ackValid && atFull;
    strobe.dec  = ackValid && !tick;
  end
endmodule

// File: rtl/refq_datapath.sv
module refq_datapath
  import refq_pkg::*;
#(
  parameter int MAX_PEND  = 12,
  parameter int HIGH_MARK = 8,
  localparam int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  refqStrobe_t       strobe,
  output logic [PEND_W-1:0] pendCount,
  output logic              overflow,
  output logic              reqLow,
  output logic              reqHigh
);
  logic [PEND_W-1:0] pendReg;
  logic              ovfReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
      ovfReg  <= 1'b0;
    end else begin
      if (strobe.inc)      pendReg <= pendReg + PEND_W'(1);
      else if (strobe.dec) pendReg <= pendReg - PEND_W'(1);
      if (strobe.drop)     ovfReg  <= 1'b1;
    end
  end

  always_comb begin
    pendCount = pendReg;
    overflow  = ovfReg;
    reqHigh   = (pendReg >= PEND_W'(HIGH_MARK));
    reqLow    = (pendReg != '0) && !reqHigh;
  end
endmodule

// File: rtl/refq_top.sv
module refq_top
  import refq_pkg::*;
#(
  parameter int TMR_W     = 16,
  parameter int MAX_PEND  = 12,
  parameter int HIGH_MARK = 8,
  localparam int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TMR_W-1:0]  intervalCnt,
  input  logic              refAck,
  output logic              reqLow,
  output logic              reqHigh,
  output logic [PEND_W-1:0] pendCount,
  output logic              overflow
);
  logic        tick;
  refqStrobe_t strobe;

  refq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rstN(rstN), .intervalCnt(intervalCnt), .tick(tick)
  );

  refq_ctrl #(.MAX_PEND(MAX_PEND)) u_ctrl (
    .tick(tick), .refAck(refAck), .pendCount(pendCount), .strobe(strobe)
  );

  refq_datapath #(.MAX_PEND(MAX_PEND), .HIGH_MARK(HIGH_MARK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendCount(pendCount),
    .overflow(overflow), .reqLow(reqLow), .reqHigh(reqHigh)
  );
endmodule

// File: rtl/refq_checker.sv
module refq_checker #(
  parameter int MAX_PEND  = 12,
  parameter int HIGH_MARK = 8,
  localparam int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              refAck,
  input logic [PEND_W-1:0] pendCount,
  input logic              reqLow,
  input logic              reqHigh,
  input logic              overflow
);
  // R2 / R3: the count moves by at most one per edge
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == $past(pendCount)) || (pendCount == $past(pendCount) + PEND_W'(1)) ||
    (pendCount + PEND_W'(1) == $past(pendCount)));

  // R4: a collision of tick and acknowledge with work owed keeps the count
  a_r4_collide_hold: assert property (@(posedge clk) disable iff (!rstN)
    (tick && refAck && pendCount != '0) |=> $stable(pendCount));

  // R5: an acknowledge on an empty queue without a tick leaves it empty
  a_r5_empty_ack: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == '0 && !tick) |=> (pendCount == '0));

  // R6: low band
  a_r6_low_band: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount != '0 && pendCount < PEND_W'(HIGH_MARK)) |-> (reqLow && !reqHigh));

  // R7: high band
  a_r7_high_band: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount >= PEND_W'(HIGH_MARK)) |-> (reqHigh && !reqLow));

  // R8: cap, stickiness and cause of the overflow flag
  a_r8_cap: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PEND_W'(MAX_PEND));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> ($past(pendCount) == PEND_W'(MAX_PEND)) && ($past(tick)));
endmodule

bind refq_top refq_checker #(.MAX_PEND(MAX_PEND), .HIGH_MARK(HIGH_MARK)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .refAck(refAck), .pendCount(pendCount),
  .reqLow(reqLow), .reqHigh(reqHigh), .overflow(overflow)
);

// File: tb/sim_refq_top.sv
module sim_refq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] intervalCnt = 16'd6;
  logic        refAck = 1'b0;
  logic        reqLow, reqHigh, overflow;
  logic [3:0]  pendCount;

  refq_top u0 (
    .clk(clk), .rstN(rstN), .intervalCnt(intervalCnt), .refAck(refAck),
    .reqLow(reqLow), .reqHigh(reqHigh), .pendCount(pendCount), .overflow(overflow)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    cnt;
    bit    low;
    bit    high;
    bit    ovf;
    string tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  int    mCnt, mTmr;
  bit    mOvf;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mCnt = 0; mTmr = 0; mOvf = 0;
  endtask

  // driver: apply ack for the coming edge, push the expected post-edge state
  task automatic step(bit a, string tag);
    int  eff;
    bit  tk, ackOk;
    item_t it;
    refAck = a;
    eff   = (intervalCnt <= 1) ? 1 : int'(intervalCnt);
    tk    = (mTmr >= eff - 1);
    mTmr  = tk ? 0 : mTmr + 1;
    ackOk = a && (mCnt > 0);
    if (tk && !ackOk) begin
      if (mCnt == 12) mOvf = 1;
      else            mCnt++;
    end else if (!tk && ackOk) begin
      mCnt--;
    end
    it.cnt  = mCnt;
    it.low  = (mCnt >= 1 && mCnt <= 7);
    it.high = (mCnt >= 8);
    it.ovf  = mOvf;
    it.tag  = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(int'(pendCount) == it.cnt, it.tag, "pendCount", int'(pendCount), it.cnt);
      check(reqLow == it.low, it.tag, "reqLow", int'(reqLow), int'(it.low));
      check(reqHigh == it.high, it.tag, "reqHigh", int'(reqHigh), int'(it.high));
      check(overflow == it.ovf, it.tag, "overflow", int'(overflow), int'(it.ovf));
    end
  end

  task automatic checkResetState(string tag);
    check(pendCount == 4'd0, tag, "pendCount in reset", int'(pendCount), 0);
    check(!reqLow && !reqHigh, tag, "requests in reset", int'({reqHigh, reqLow}), 0);
    check(overflow == 1'b0, tag, "overflow in reset", int'(overflow), 0);
  endtask

  initial begin
    #1_600_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkResetState("R9");
    rstN = 1'b1; modelReset();

    // R1: first tick on edge N=6; R2 R6 R7 R8 climb to full, then drop
    for (int i = 0; i < 6; i++) step(1'b0, "R1");
    for (int i = 0; i < 90; i++) step(1'b0, "R2 R6 R7 R8");
    // R3 R5: drain with an ack every cycle, overflow stays set
    for (int i = 0; i < 40; i++) step(1'b1, "R3 R5 R8");
    // R4 R6 R7: random acks, dense ticks
    intervalCnt = 16'd3;
    for (int i = 0; i < 200; i++) step($urandom_range(3) == 0, "R4 R6 R7");
    for (int i = 0; i < 200; i++) step($urandom_range(1) == 0, "R4 R5 R3");

    // R9: reset mid-run clears count, flag and timer phase
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkResetState("R9");
    intervalCnt = 16'd5;
    rstN = 1'b1; modelReset();
    for (int i = 0; i < 12; i++) step(1'b0, "R9 R1");

    // R10: intervals 1 and 0 tick every edge
    intervalCnt = 16'd1;
    for (int i = 0; i < 30; i++) step($urandom_range(2) == 0, "R10");
    intervalCnt = 16'd0;
    for (int i = 0; i < 30; i++) step($urandom_range(2) == 0, "R10");
    refAck = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule